// File: doc/BRIEF.md
# Indirect Data Address Pointer Unit

This block keeps a set of indirect data-memory pointers (three by default, 12 bits each) and serves the register-file addresses through which a processor core reaches memory by pointer. Every pointer owns a small group of register addresses. Five of them are aliases with no storage behind them: any access to an alias is passed on to data memory at an address computed from the pointer. Each alias has its own effect on the pointer: none, step after the access (up or down), step up before the access, or a one-off offset by the working register. The other two addresses of the group hold the pointer's low byte and its high nibble, which can be read and written directly.

The block has a read port and a write port that work in the same cycle, as a register-to-register move needs. Each port drives its own data-memory address with a strobe. Pointer changes from both ports are merged and take effect at the next clock edge. The data memory, bank selection and instruction decode sit outside.

Top module: `ind_ptr_unit`

## Requirements
- R1: On reset the high nibble of every pointer clears to 0. Reading a high half always returns 0 in data bits 7:4. The low byte is not reset.
- R2: Pointer p owns register addresses BASE+8p+k (default BASE 0xC0). k=0 plain, 1 step up after, 2 step down after, 3 step up before, 4 working-register offset, 5 low byte, 6 high nibble. Offset 7, and any address outside BASE..BASE+8*NUM_PTR-1, raise no strobe, read as 0 and change no pointer.
- R3: A plain-alias access puts the pointer on the memory address and leaves the pointer as it was.
- R4: The step-after aliases use the current pointer as the address. In the next cycle the pointer is one higher (k=1) or one lower (k=2).
- R5: The step-before alias uses pointer+1 as the address, and the pointer holds that value in the next cycle.
- R6: The offset alias uses pointer + the working register, the working register taken as signed 8-bit and sign-extended. The pointer is not changed.
- R7: All address and pointer arithmetic wraps modulo 4096. A carry or borrow between the low byte and the high nibble takes effect in the same update.
- R8: An alias read raises the read strobe and returns the memory read data. An alias write raises the write strobe and forwards the write data unchanged.
- R9: A direct write sets bits 7:0 (k=5) or bits 11:8 from data bits 3:0 (k=6), and shows from the next cycle. A direct read returns the half as it was at the start of the cycle.
- R10: When a direct write to a pointer half meets an alias step of the same pointer in one cycle, the written half takes the data, the other half keeps its old value, and the step is dropped.
- R11: Steps from both ports on the same pointer add up. Each port forms its address from the pointer value at the start of the cycle.
- R12: The read strobe is high only when the read enable is high and the read address is an alias. The write strobe follows the same rule for the write port. With an enable low, that port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read port access enable |
| rd_addr | input | RA_W | Read port register address |
| rd_data | output | DATA_W | Read result to the core |
| wr_en | input | 1 | Write port access enable |
| wr_addr | input | RA_W | Write port register address |
| wr_data | input | DATA_W | Write port data |
| wreg | input | DATA_W | Working register value used as the offset |
| mem_rdata | input | DATA_W | Data returned by data memory for the read address |
| mem_re | output | 1 | Read effective address valid |
| mem_raddr | output | PTR_W | Read effective address |
| mem_we | output | 1 | Write effective address valid |
| mem_waddr | output | PTR_W | Write effective address |
| mem_wdata | output | DATA_W | Data to data memory |
| ptr_all | output | NUM_PTR*PTR_W | Current pointer values, pointer p at bits p*PTR_W upward |

## Verification
Every alias of every pointer is tried from start values at the byte and word edges (0x000, 0x0FF, 0x100, 0x7FF, 0x800, 0xFFF). This tells a wrong or missing carry or borrow apart from a wrong step direction or a step on the wrong pointer. The offset alias is swept over all 256 working-register values from a pointer near the top of the range. That sweep separates sign extension from zero extension and catches wrap errors. Paired-port cycles give a direct write against a step and two steps on one pointer, which show whether the priority and merge rules hold. Unmapped offsets and disabled ports show that no stray strobe or pointer change occurs.

// File: rtl/ind_ptr_pkg.sv
`timescale 1ns/1ps
package ind_ptr_pkg;

   // Code values equal the offset inside a pointer's address group.
   typedef enum logic [2:0] {
      K_PLAIN   = 3'd0,
      K_POSTINC = 3'd1,
      K_POSTDEC = 3'd2,
      K_PREINC  = 3'd3,
      K_PLUSW   = 3'd4,
      K_DIRLO   = 3'd5,
      K_DIRHI   = 3'd6,
      K_NONE    = 3'd7
   } acc_kind_e;

   localparam int unsigned GROUP_SPAN = 8;
   localparam int unsigned GROUP_SH   = 3;

   function automatic logic is_alias(acc_kind_e k);
      return (k == K_PLAIN) || (k == K_POSTINC) || (k == K_POSTDEC) ||
             (k == K_PREINC) || (k == K_PLUSW);
   endfunction

   function automatic logic signed [2:0] step_of(acc_kind_e k);
      case (k)
         K_POSTINC, K_PREINC: return 3'sd1;
         K_POSTDEC:           return -3'sd1;
         default:             return 3'sd0;
      endcase
   endfunction

endpackage

// File: rtl/ind_ptr_decode.sv
`timescale 1ns/1ps
module ind_ptr_decode
   import ind_ptr_pkg::*;
#(
   parameter int unsigned     RA_W    = 8,
   parameter int unsigned     NUM_PTR = 3,
   parameter logic [RA_W-1:0] BASE    = 8'hC0,
   parameter int unsigned     IDX_W   = 2
) (
   input  logic             en,
   input  logic [RA_W-1:0]  addr,
   output acc_kind_e        kind,
   output logic [IDX_W-1:0] idx
);
   localparam int unsigned SPAN = NUM_PTR * GROUP_SPAN;

   logic [RA_W-1:0] rel;
   logic            in_win;

   assign rel    = addr - BASE;
   assign in_win = (addr >= BASE) && (32'(rel) < SPAN);

   always_comb begin
      kind = K_NONE;
      idx  = '0;
      if (en && in_win) begin
         idx  = IDX_W'(rel >> GROUP_SH);
         kind = acc_kind_e'(rel[GROUP_SH-1:0]);
      end
   end

endmodule

// File: rtl/ind_ptr_agen.sv
`timescale 1ns/1ps
module ind_ptr_agen
   import ind_ptr_pkg::*;
#(
   parameter int unsigned PTR_W      = 12,
   parameter int unsigned DATA_W     = 8,
   parameter bit          SIGNED_OFS = 1'b1
) (
   input  logic [PTR_W-1:0]  ptr,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] wreg,
   output logic [PTR_W-1:0]  ea
);
   localparam int unsigned EXT_W = PTR_W - DATA_W;

   logic [PTR_W-1:0] ofs;

   generate
      if (SIGNED_OFS) begin : g_sext
         assign ofs = {{EXT_W{wreg[DATA_W-1]}}, wreg};
      end else begin : g_zext
         assign ofs = {{EXT_W{1'b0}}, wreg};
      end
   endgenerate

   always_comb begin
      case (kind)
         K_PREINC: ea = ptr + PTR_W'(1);
         K_PLUSW:  ea = ptr + ofs;
         default:  ea = ptr;
      endcase
   end

endmodule

// File: rtl/ind_ptr_slot.sv
`timescale 1ns/1ps
module ind_ptr_slot #(
   parameter int unsigned PTR_W  = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic signed [2:0] step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);
   localparam int unsigned HI_W = PTR_W - DATA_W;

   logic [DATA_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;
   logic [PTR_W-1:0]  stepped;

   assign ptr     = {hi_q, lo_q};
   assign stepped = ptr + {{(PTR_W-3){step[2]}}, step};

   // Low byte carries no reset: its value after reset is left open.
   always_ff @(posedge clk) begin
      if (wr_lo)       lo_q <= wdata;
      else if (!wr_hi) lo_q <= stepped[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_q <= '0;
      else if (wr_hi)  hi_q <= wdata[HI_W-1:0];
      else if (!wr_lo) hi_q <= stepped[PTR_W-1:DATA_W];
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'sd0 && !wr_lo && !wr_hi) |=> $stable(ptr)); // R3
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'sd1 && !wr_lo && !wr_hi) |=> (ptr == $past(ptr) + PTR_W'(1))); // R4
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step == -3'sd1 && !wr_lo && !wr_hi) |=> (ptr == $past(ptr) - PTR_W'(1))); // R4
   AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (ptr[DATA_W-1:0] == $past(wdata))); // R10
   AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0]))); // R10

endmodule

// File: rtl/ind_ptr_unit.sv
`timescale 1ns/1ps
module ind_ptr_unit
   import ind_ptr_pkg::*;
#(
   parameter int unsigned     NUM_PTR    = 3,
   parameter int unsigned     PTR_W      = 12,
   parameter int unsigned     DATA_W     = 8,
   parameter int unsigned     RA_W       = 8,
   parameter logic [RA_W-1:0] BASE       = 8'hC0,
   parameter bit              SIGNED_OFS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [RA_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     wr_en,
   input  logic [RA_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [DATA_W-1:0]        wreg,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic                     mem_re,
   output logic [PTR_W-1:0]         mem_raddr,
   output logic                     mem_we,
   output logic [PTR_W-1:0]         mem_waddr,
   output logic [DATA_W-1:0]        mem_wdata,
   output logic [NUM_PTR*PTR_W-1:0] ptr_all
);
   localparam int unsigned IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
   localparam int unsigned HI_W  = PTR_W - DATA_W;

   generate
      if (PTR_W <= DATA_W) begin : g_chk_w_lo
         $error("PTR_W must exceed DATA_W");
      end
      if (HI_W >= DATA_W) begin : g_chk_w_hi
         $error("high half must be narrower than DATA_W");
      end
      if (NUM_PTR < 1) begin : g_chk_n
         $error("NUM_PTR must be at least 1");
      end
      if (int'(BASE) + NUM_PTR * GROUP_SPAN > (1 << RA_W)) begin : g_chk_map
         $error("pointer groups do not fit the register address space");
      end
   endgenerate

   acc_kind_e        rd_kind, wr_kind;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [PTR_W-1:0] ptr_q [NUM_PTR];
   logic [PTR_W-1:0] rd_sel, wr_sel;

   ind_ptr_decode #(.RA_W(RA_W), .NUM_PTR(NUM_PTR), .BASE(BASE), .IDX_W(IDX_W)) rd_dec_i (
      .en(rd_en), .addr(rd_addr), .kind(rd_kind), .idx(rd_idx));

   ind_ptr_decode #(.RA_W(RA_W), .NUM_PTR(NUM_PTR), .BASE(BASE), .IDX_W(IDX_W)) wr_dec_i (
      .en(wr_en), .addr(wr_addr), .kind(wr_kind), .idx(wr_idx));

   always_comb begin
      rd_sel = '0;
      wr_sel = '0;
      for (int p = 0; p < NUM_PTR; p++) begin
         if (rd_idx == IDX_W'(p)) rd_sel = ptr_q[p];
         if (wr_idx == IDX_W'(p)) wr_sel = ptr_q[p];
      end
   end

   ind_ptr_agen #(.PTR_W(PTR_W), .DATA_W(DATA_W), .SIGNED_OFS(SIGNED_OFS)) rd_agen_i (
      .ptr(rd_sel), .kind(rd_kind), .wreg(wreg), .ea(mem_raddr));

   ind_ptr_agen #(.PTR_W(PTR_W), .DATA_W(DATA_W), .SIGNED_OFS(SIGNED_OFS)) wr_agen_i (
      .ptr(wr_sel), .kind(wr_kind), .wreg(wreg), .ea(mem_waddr));

   generate
      for (genvar p = 0; p < NUM_PTR; p++) begin : g_slot
         logic signed [2:0] s_rd, s_wr, s_sum;
         logic              hit_lo, hit_hi;

         assign s_rd   = (rd_idx == IDX_W'(p)) ? step_of(rd_kind) : 3'sd0;
         assign s_wr   = (wr_idx == IDX_W'(p)) ? step_of(wr_kind) : 3'sd0;
         assign s_sum  = s_rd + s_wr;
         assign hit_lo = (wr_kind == K_DIRLO) && (wr_idx == IDX_W'(p));
         assign hit_hi = (wr_kind == K_DIRHI) && (wr_idx == IDX_W'(p));

         ind_ptr_slot #(.PTR_W(PTR_W), .DATA_W(DATA_W)) slot_i (
            .clk(clk), .rst_n(rst_n), .step(s_sum),
            .wr_lo(hit_lo), .wr_hi(hit_hi), .wdata(wr_data), .ptr(ptr_q[p]));

         assign ptr_all[p*PTR_W +: PTR_W] = ptr_q[p];
      end
   endgenerate

   assign mem_re    = is_alias(rd_kind);
   assign mem_we    = is_alias(wr_kind);
   assign mem_wdata = wr_data;

   always_comb begin
      case (rd_kind)
         K_PLAIN, K_POSTINC, K_POSTDEC, K_PREINC, K_PLUSW: rd_data = mem_rdata;
         K_DIRLO: rd_data = rd_sel[DATA_W-1:0];
         K_DIRHI: rd_data = {{(DATA_W-HI_W){1'b0}}, rd_sel[PTR_W-1:DATA_W]};
         default: rd_data = '0;
      endcase
   end

   AST_RE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> rd_en); // R12
   AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wr_en); // R12
   AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == K_PLAIN) |-> (mem_raddr == rd_sel)); // R3
   AST_ALIAS_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (rd_data == mem_rdata)); // R8
   AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == K_DIRHI) |-> (rd_data[DATA_W-1:HI_W] == '0)); // R1
   AST_IDLE_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |=> $stable(ptr_all)); // R12

endmodule

// File: tb/ind_ptr_unit_tb.sv
`timescale 1ns/1ps
module ind_ptr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  rd_addr = '0, wr_addr = '0, wr_data = '0, wreg = '0;
   logic [7:0]  rd_data, mem_rdata, mem_wdata;
   logic        mem_re, mem_we;
   logic [11:0] mem_raddr, mem_waddr;
   logic [35:0] ptr_all;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [11:0] mp [3];

   always #2.5 clk = ~clk;

   // Memory model: returned data is a function of the read address.
   assign mem_rdata = mem_raddr[7:0] ^ 8'h5A;

   ind_ptr_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wreg(wreg),
      .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .ptr_all(ptr_all));

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int kind_of(logic [7:0] a);
      int off;
      if (a < 8'hC0 || a >= 8'hD8) return -1;
      off = int'(a - 8'hC0) % 8;
      return (off == 7) ? -1 : off;
   endfunction

   function automatic int idx_of(logic [7:0] a);
      return int'(a - 8'hC0) / 8;
   endfunction

   function automatic logic [11:0] ea_of(int k, logic [11:0] p, logic [7:0] w);
      if (k == 3) return p + 12'd1;
      if (k == 4) return p + {{4{w[7]}}, w};
      return p;
   endfunction

   function automatic int step_of(int k);
      if (k == 1 || k == 3) return 1;
      if (k == 2) return -1;
      return 0;
   endfunction

   task automatic cyc(bit re, logic [7:0] ra, bit we, logic [7:0] wa,
                      logic [7:0] wd, logic [7:0] w, string tag);
      int rk, wk, ri, wi;
      logic [11:0] rea, wea;
      logic [11:0] nxt [3];
      logic [7:0]  exp_rd;
      @(negedge clk);
      rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd; wreg = w;
      #1;
      rk = re ? kind_of(ra) : -1;
      wk = we ? kind_of(wa) : -1;
      ri = (rk >= 0) ? idx_of(ra) : 0;
      wi = (wk >= 0) ? idx_of(wa) : 0;
      rea = ea_of(rk, mp[ri], w);
      wea = ea_of(wk, mp[wi], w);
      chk(mem_re == (rk >= 0 && rk <= 4), tag, "read strobe", int'(mem_re), int'(rk >= 0 && rk <= 4));
      if (rk >= 0 && rk <= 4) begin
         chk(mem_raddr == rea, tag, "read address", int'(mem_raddr), int'(rea));
         exp_rd = rea[7:0] ^ 8'h5A;
      end else if (rk == 5) exp_rd = mp[ri][7:0];
      else if (rk == 6)     exp_rd = {4'h0, mp[ri][11:8]};
      else                  exp_rd = 8'h00;
      chk(rd_data == exp_rd, tag, "read data", int'(rd_data), int'(exp_rd));
      chk(mem_we == (wk >= 0 && wk <= 4), tag, "write strobe", int'(mem_we), int'(wk >= 0 && wk <= 4));
      if (wk >= 0 && wk <= 4) begin
         chk(mem_waddr == wea, tag, "write address", int'(mem_waddr), int'(wea));
         chk(mem_wdata == wd, tag, "write data", int'(mem_wdata), int'(wd));
      end
      for (int p = 0; p < 3; p++) begin
         int d;
         d = 0;
         if (rk >= 0 && ri == p) d += step_of(rk);
         if (wk >= 0 && wi == p) d += step_of(wk);
         nxt[p] = mp[p];
         if (wk == 5 && wi == p)      nxt[p][7:0]  = wd;
         else if (wk == 6 && wi == p) nxt[p][11:8] = wd[3:0];
         else                         nxt[p] = mp[p] + 12'(d);
      end
      @(posedge clk);
      #1;
      for (int p = 0; p < 3; p++) begin
         mp[p] = nxt[p];
         chk(ptr_all[p*12 +: 12] == mp[p], tag, $sformatf("pointer %0d", p),
             int'(ptr_all[p*12 +: 12]), int'(mp[p]));
      end
   endtask

   task automatic set_ptr(int p, logic [11:0] v);
      cyc(1'b0, 8'h00, 1'b1, 8'(8'hC5 + 8*p), v[7:0], 8'h00, "R9");
      cyc(1'b0, 8'h00, 1'b1, 8'(8'hC6 + 8*p), {4'hF, v[11:8]}, 8'h00, "R9");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [11:0] starts [6];
      starts = '{12'h000, 12'h0FF, 12'h100, 12'h7FF, 12'h800, 12'hFFF};
      repeat (3) @(negedge clk);
      // R1: high nibbles clear and no strobes while in reset
      for (int p = 0; p < 3; p++)
         chk(ptr_all[p*12+8 +: 4] == 4'h0, "R1", "reset high nibble", int'(ptr_all[p*12+8 +: 4]), 0);
      chk(!mem_re && !mem_we, "R1", "strobes in reset", int'({mem_re, mem_we}), 0);
      rst_n = 1'b1;
      // Low byte after reset is open: adopt what the port shows.
      for (int p = 0; p < 3; p++) mp[p] = {4'h0, ptr_all[p*12 +: 8]};
      // R1 R9: direct half reads, upper read bits zero
      for (int p = 0; p < 3; p++) begin
         set_ptr(p, 12'(12'h5A3 + 16*p));
         cyc(1'b1, 8'(8'hC5 + 8*p), 1'b0, 8'h00, 8'h00, 8'h00, "R9");
         cyc(1'b1, 8'(8'hC6 + 8*p), 1'b0, 8'h00, 8'h00, 8'h00, "R1 R9");
      end
      // R3 R4 R5 R6 R7 R8: every alias of every pointer from edge values
      for (int p = 0; p < 3; p++)
         for (int k = 0; k < 5; k++)
            for (int s = 0; s < 6; s++) begin
               string tg;
               tg = (k == 0) ? "R3 R7 R8" : (k == 3) ? "R5 R7 R8" :
                    (k == 4) ? "R6 R7 R8" : "R4 R7 R8";
               set_ptr(p, starts[s]);
               cyc(1'b1, 8'(8'hC0 + 8*p + k), 1'b0, 8'h00, 8'h00, 8'(8'h81 + 37*s), tg);
               cyc(1'b0, 8'h00, 1'b1, 8'(8'hC0 + 8*p + k), 8'(8'h3C + s), 8'(8'h7F - 29*s), tg);
            end
      // R6 R7: exhaustive working-register sweep on the offset alias
      set_ptr(1, 12'hFF0);
      for (int w = 0; w < 256; w++)
         cyc(1'b1, 8'hCC, 1'b0, 8'h00, 8'h00, 8'(w), "R6 R7");
      // R2: unused group offset and addresses outside the window
      set_ptr(2, 12'h234);
      cyc(1'b1, 8'hC7, 1'b1, 8'hD7, 8'h99, 8'h05, "R2");
      cyc(1'b1, 8'hD8, 1'b1, 8'hBF, 8'h99, 8'h05, "R2");
      cyc(1'b1, 8'h00, 1'b1, 8'hFF, 8'h99, 8'h05, "R2");
      // R12: enables low on alias addresses
      cyc(1'b0, 8'hC1, 1'b0, 8'hD1, 8'h11, 8'h00, "R12");
      cyc(1'b0, 8'hC3, 1'b1, 8'hC7, 8'h11, 8'h00, "R12");
      // R10: direct write against a step on the same pointer
      set_ptr(0, 12'h1FF);
      cyc(1'b1, 8'hC1, 1'b1, 8'hC5, 8'h33, 8'h00, "R10");
      cyc(1'b1, 8'hC3, 1'b1, 8'hC6, 8'h0A, 8'h00, "R10");
      cyc(1'b1, 8'hC2, 1'b1, 8'hC6, 8'h0F, 8'h00, "R10");
      // R11: both ports on one pointer
      set_ptr(2, 12'hFFF);
      cyc(1'b1, 8'hD1, 1'b1, 8'hD1, 8'h44, 8'h00, "R11");
      cyc(1'b1, 8'hD2, 1'b1, 8'hD1, 8'h45, 8'h00, "R11");
      cyc(1'b1, 8'hD3, 1'b1, 8'hD3, 8'h46, 8'h00, "R11");
      cyc(1'b1, 8'hCA, 1'b1, 8'hD2, 8'h47, 8'h00, "R11");
      cyc(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, "R12");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule